// File: doc/BRIEF.md
# SAR Converter Serial Frame Responder

This block is the device-side digital interface of a two-channel successive-approximation converter. A host frames each transfer with an active-low chip select and clocks it with a serial clock. Both arrive as plain inputs and are oversampled by the block's own clock. The block answers on a serial data line that has a separate output enable. It counts serial-clock edges inside each frame and marks the edge where conversion ends and acquisition begins. It also decides whether the host is running short 16-clock frames or long 32-clock frames, and it picks the word to shift out to match. A simple stand-in core produces a recognisable result word for each sample, so the framing can be checked without any analog model.

The frame length is never configured; the block works it out from the number of serial clocks seen while chip select stays low. In short frames, the word shifted out belongs to the sample taken in the previous frame. In long frames, the word for the current sample follows from the 16th falling edge on, and the first 16 bit times of the next frame then carry zeros. A channel-select input is captured at each conversion end and applies to the next sample. A power-down request is captured on each chip-select rising edge.

Top module: `sfr_frame_responder`

## Requirements
- R1: While chip select is high, `sdo_oe` is 0, and `sdo` is 0 whenever `sdo_oe` is 0.
- R2: On a chip-select falling edge, `sdo_oe` goes to 1 and `sdo` presents the MSB of the word chosen for that frame.
- R3: Each serial-clock falling edge with chip select low advances `sdo` to the next lower bit. After the LSB, `sdo` stays 0 until the 16th falling edge.
- R4: Conversion ends on serial-clock rising edge 14 for 12-bit resolution and on rising edge RES+1 for 10 and 8 bits. `conv_done` pulses for one clock cycle there. A frame whose chip select rises earlier produces no pulse and leaves the stored result unchanged.
- R5: When the frame before was short, bits 0 to RES-1 of a frame (MSB first) are the result of the most recent completed conversion. After reset this result is 0.
- R6: From the 16th falling edge on, `sdo` shifts out the result converted in the current frame, MSB first, followed by zeros.
- R7: `long_mode` becomes 1 at the 30th falling edge with chip select low. It returns to 0 when chip select rises after fewer than 30 falling edges.
- R8: After a frame that reached 30 falling edges, the first 16 bit times of the next frame are all 0.
- R9: The result word has the channel in its MSB (0 = channel 0, 1 = channel 1). The lower RES-1 bits hold the sample index modulo 2^(RES-1); the index counts chip-select falling edges since reset and starts at 0. The channel used for a sample is the `ch_sel` value at the previous conversion end (0 after reset).
- R10: `pd_latched` takes the value of `pd_req` at each chip-select rising edge. Changes on `pd_req` at any other time have no effect.
- R11: Edge counts saturate at 32 and restart at every chip-select falling edge. Extra serial clocks shift only zeros and do not disturb the following frame.
- R12: After reset, `sdo_oe`, `sdo`, `conv_done`, `long_mode` and `pd_latched` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| ch_sel | input | 1 | Channel choice for the next sample |
| pd_req | input | 1 | Power-down request, captured on chip-select rise |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data line |
| conv_done | output | 1 | One-cycle strobe at the conversion-end edge |
| long_mode | output | 1 | 1 while the 32-clock frame format is in force |
| pd_latched | output | 1 | Captured power-down request |

## Verification
A wrong edge count appears within the same frame: `conv_done` lands on the wrong serial edge, or the reload at the 16th falling edge moves, and the bits after it shift by the same amount. A stale or corrupted stored result stays hidden until the next frame, which then shows wrong leading bits. A wrong mode flag shows up in two ways: `long_mode` reads wrong right after chip select rises, and the following frame carries a non-zero head where zeros were due, or the reverse. The bench sweeps every frame length from 1 to 33 clocks and compares every shifted bit with a word computed from the sample index and channel.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int CNT_MAX = 32;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef logic [CNT_W-1:0] edge_cnt_t;

    // rising edge on which conversion completes for a given resolution
    function automatic int conv_edge(input int res);
        return (res == 12) ? 14 : res + 1;
    endfunction

endpackage

// File: rtl/sfr_edge_track.sv
module sfr_edge_track
    import sfr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      sclk,
    output logic      cs_fall,
    output logic      cs_rise,
    output logic      sclk_rise,
    output logic      sclk_fall,
    output edge_cnt_t rise_num,
    output edge_cnt_t fall_num,
    output edge_cnt_t fall_cnt
);

    typedef struct packed {
        logic      cs;
        logic      sclk;
        edge_cnt_t rises;
        edge_cnt_t falls;
    } trk_t;

    localparam edge_cnt_t SAT = edge_cnt_t'(CNT_MAX);

    trk_t q, d;

    always_comb begin
        cs_fall   = q.cs & ~cs_n;
        cs_rise   = ~q.cs & cs_n;
        sclk_rise = ~cs_n & ~q.cs & sclk & ~q.sclk;
        sclk_fall = ~cs_n & ~q.cs & ~sclk & q.sclk;
        rise_num  = (q.rises == SAT) ? SAT : q.rises + 1'b1;
        fall_num  = (q.falls == SAT) ? SAT : q.falls + 1'b1;
        fall_cnt  = q.falls;

        d      = q;
        d.cs   = cs_n;
        d.sclk = sclk;
        if (cs_fall) begin
            d.rises = '0;
            d.falls = '0;
        end else begin
            if (sclk_rise) d.rises = rise_num;
            if (sclk_fall) d.falls = fall_num;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cs    <= 1'b1;
            q.sclk  <= 1'b0;
            q.rises <= '0;
            q.falls <= '0;
        end else begin
            q <= d;
        end
    end

    // R11: counters never pass the saturation value
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rises <= SAT) && (q.falls <= SAT));

    // R11: a chip-select falling edge restarts the falling-edge count
    a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (fall_cnt == '0));

endmodule

// File: rtl/sfr_result_stub.sv
module sfr_result_stub #(
    parameter int RES = 12
) (
    input  logic           ch,
    input  logic [RES-2:0] idx,
    output logic [RES-1:0] word
);

    // stand-in for the converter core: channel in MSB, sample index below
    always_comb begin
        word = {ch, idx};
    end

endmodule

// File: rtl/sfr_frame_responder.sv
module sfr_frame_responder
    import sfr_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic ch_sel,
    input  logic pd_req,
    output logic sdo,
    output logic sdo_oe,
    output logic conv_done,
    output logic long_mode,
    output logic pd_latched
);

    localparam int IDX_W      = RES - 1;
    localparam int CONV_AT    = conv_edge(RES);
    localparam int RELOAD_AT  = 16;
    localparam int LONG_AT    = 30;

    localparam edge_cnt_t CONV_E   = edge_cnt_t'(CONV_AT);
    localparam edge_cnt_t RELOAD_E = edge_cnt_t'(RELOAD_AT);
    localparam edge_cnt_t LONG_E   = edge_cnt_t'(LONG_AT);

    typedef struct packed {
        logic [RES-1:0]   shift;
        logic             oe;
        logic [IDX_W-1:0] next_idx;
        logic [IDX_W-1:0] samp_idx;
        logic             samp_ch;
        logic             ch_next;
        logic [RES-1:0]   last;
        logic             zero_next;
        logic             long_fr;
        logic             pd;
        logic             done;
    } rsp_t;

    rsp_t q, d;

    logic      cs_fall, cs_rise, sclk_rise, sclk_fall;
    edge_cnt_t rise_num, fall_num, fall_cnt;
    logic [RES-1:0] core_word;

    sfr_edge_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rise_num  (rise_num),
        .fall_num  (fall_num),
        .fall_cnt  (fall_cnt)
    );

    sfr_result_stub #(.RES(RES)) u_core (
        .ch   (q.samp_ch),
        .idx  (q.samp_idx),
        .word (core_word)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;

        if (cs_fall) begin
            d.oe        = 1'b1;
            d.shift     = q.zero_next ? '0 : q.last;
            d.zero_next = 1'b0;
            d.samp_idx  = q.next_idx;
            d.samp_ch   = q.ch_next;
            d.next_idx  = q.next_idx + 1'b1;
        end

        if (cs_rise) begin
            d.oe = 1'b0;
            d.pd = pd_req;
            if (fall_cnt < LONG_E) d.long_fr = 1'b0;
        end

        if (sclk_rise && (rise_num == CONV_E)) begin
            d.done    = 1'b1;
            d.last    = core_word;
            d.ch_next = ch_sel;
        end

        if (sclk_fall) begin
            if (fall_num == RELOAD_E) begin
                d.shift = q.last;
            end else begin
                d.shift = {q.shift[RES-2:0], 1'b0};
            end
            if (fall_num == LONG_E) begin
                d.long_fr   = 1'b1;
                d.zero_next = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo        = q.oe & q.shift[RES-1];
    assign sdo_oe     = q.oe;
    assign conv_done  = q.done;
    assign long_mode  = q.long_fr;
    assign pd_latched = q.pd;

    // R1: chip select high forces the output enable off next cycle
    a_r1_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_oe);

    // R1: data line quiet while not enabled
    a_r1_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R4: conversion-end strobe lasts one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    // R4: strobe only follows an edge seen with chip select low
    a_r4_done_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(!cs_n));

    // R7: long-frame flag is only raised inside a frame
    a_r7_long_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_mode) |-> !cs_n);

    // R8: head of a frame after a long frame is zero
    a_r8_zero_head: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && q.zero_next) |=> !sdo);

    // R10: captured power-down request holds while chip select is low
    a_r10_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> $stable(pd_latched));

endmodule

// File: tb/sim_sfr_frame_responder.sv
module sim_sfr_frame_responder;

    localparam int CLK_PERIOD = 10;
    localparam int RES        = 12;
    localparam int CONV_AT    = (RES == 12) ? 14 : RES + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic ch_sel = 1'b0;
    logic pd_req = 1'b0;
    logic sdo, sdo_oe, conv_done, long_mode, pd_latched;

    int n_tests = 0;
    int n_fail  = 0;
    int done_seen = 0;
    bit finished = 1'b0;

    // bench model
    int             k_idx   = 0;
    logic           ch_mod  = 1'b0;
    logic [RES-1:0] prev_w  = '0;
    bit             zn_mod  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfr_frame_responder #(.RES(RES)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .ch_sel     (ch_sel),
        .pd_req     (pd_req),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .conv_done  (conv_done),
        .long_mode  (long_mode),
        .pd_latched (pd_latched)
    );

    always @(posedge clk) if (conv_done) done_seen <= done_seen + 1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input int n, input logic ch, input logic pd);
        logic [RES-1:0] this_w;
        logic [63:0] got, exp_h, got_h, exp_t, got_t;
        bit convd;
        this_w = {ch_mod, (RES-1)'(k_idx)};
        convd  = (n >= CONV_AT);
        got = '0; exp_h = '0; got_h = '0; exp_t = '0; got_t = '0;

        @(negedge clk);
        ch_sel = ch;
        pd_req = ~pd;
        cs_n   = 1'b0;
        repeat (3) @(negedge clk);
        got[0] = sdo;
        check(sdo_oe === 1'b1, "R2 oe in frame", 64'(sdo_oe), 64'd1);
        for (int j = 1; j <= n; j++) begin
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
            repeat (3) @(negedge clk);
            if (j < 64) got[j] = sdo;
        end
        pd_req = pd;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int b = 0; b <= n && b < 64; b++) begin
            if (b < 16) begin
                got_h[b] = got[b];
                exp_h[b] = (b < RES && !zn_mod) ? prev_w[RES-1-b] : 1'b0;
            end else begin
                got_t[b] = got[b];
                exp_t[b] = (b - 16 < RES && convd) ? this_w[RES-1-(b-16)] : 1'b0;
            end
        end
        if (zn_mod)
            check(got_h === exp_h, "R8 R3 zero head", got_h, exp_h);
        else
            check(got_h === exp_h, "R5 R2 R3 R9 head word", got_h, exp_h);
        check(got_t === exp_t, "R6 R11 tail bits", got_t, exp_t);
        check(done_seen == (convd ? 1 : 0), "R4 conv_done count",
              64'(done_seen), convd ? 64'd1 : 64'd0);
        check(long_mode === (n >= 30), "R7 long_mode", 64'(long_mode), 64'(n >= 30));
        check(sdo_oe === 1'b0 && sdo === 1'b0, "R1 idle output",
              {62'd0, sdo_oe, sdo}, 64'd0);
        check(pd_latched === pd, "R10 pd capture", 64'(pd_latched), 64'(pd));
        pd_req = ~pd;
        repeat (3) @(negedge clk);
        check(pd_latched === pd, "R10 pd ignored while high", 64'(pd_latched), 64'(pd));
        done_seen = 0;

        k_idx++;
        if (convd) begin
            prev_w = this_w;
            ch_mod = ch;
        end
        zn_mod = (n >= 30);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sdo_oe === 1'b0 && sdo === 1'b0 && conv_done === 1'b0 &&
              long_mode === 1'b0 && pd_latched === 1'b0, "R12 reset state",
              {59'd0, sdo_oe, sdo, conv_done, long_mode, pd_latched}, 64'd0);
        done_seen = 0;
        for (int n = 1; n <= 33; n++) begin
            run_frame(n, logic'(n[0] ^ n[2]), logic'(n[1]));
        end
        run_frame(30, 1'b1, 1'b0);
        run_frame(31, 1'b0, 1'b1);
        run_frame(16, 1'b1, 1'b0);
        run_frame(5,  1'b0, 1'b1);
        run_frame(14, 1'b1, 1'b1);
        run_frame(16, 1'b0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule